// File: doc/BRIEF.md
# Two-Prescaler Channel Tick Divider

This block turns one fixed reference clock (nominally 24 MHz) into five independent count-enable strobes for a five-channel timer. Two 8-bit prescalers divide the reference clock. The first prescaler feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. Each channel then adds its own power-of-two divider. A channel with prescaler value P and divider-select value d asserts its tick for one clock every (P+1)·2^d cycles.

Two configuration words hold the settings. The prescaler word carries prescaler 0 in bits [7:0] and prescaler 1 in bits [15:8]. The divider word carries the 4-bit select of channel x in bits [4x+3:4x]. Both words are written through a single-cycle write port and read back through a combinational read port. A write never restarts a running counter. A new prescaler value is first used when that prescaler next reloads, and a new divider select is first used when that channel's divider next reloads. Divider selects above 7 are treated as 7, which bounds the divider counter to 7 bits.

Top module: `tick_divider`

## Requirements
- R1: While reset is asserted and right after it, the prescaler word reads 0x0101 and the divider word reads 0.
- R2: A write with `wr_sel`=0 stores `wr_data[15:0]` into the prescaler word from the next cycle on. Prescaler 0 is bits [7:0] and prescaler 1 is bits [15:8]. With `rd_sel`=0, `rd_data` shows the word in the same cycle, and bits [31:16] read as zero.
- R3: A write with `wr_sel`=1 stores `wr_data[19:0]` into the divider word. The select for channel x is bits [4x+3:4x]. With `rd_sel`=1, `rd_data` shows the word, and bits [31:20] read as zero.
- R4: Channels 0 and 1 count pulses of prescaler 0. Channels 2, 3 and 4 count pulses of prescaler 1.
- R5: In steady state, channel x ticks for exactly one cycle every (P+1)·2^d cycles. P is its prescaler value and d is its select value.
- R6: A select value from 8 to 15 divides by 128, the same as a select value of 7.
- R7: In the first cycle after reset is released, all five ticks are high, because every counter starts at zero.
- R8: A configuration write does not restart any counter. A prescaler that is already counting completes its old count before it loads the new value. A channel divider uses a new select only when it next reloads.
- R9: With both prescalers at 0 and all selects at 0, every tick is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for a configuration word |
| wr_sel | input | 1 | Word to write: 0 for the prescaler word, 1 for the divider word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Word to read: 0 for the prescaler word, 1 for the divider word |
| rd_data | output | 32 | Selected word, zero-extended |
| tick | output | 5 | One-cycle count-enable strobe per channel |

## Verification
`rd_data` is combinational. It is checked in the same cycle as `rd_sel`, and it is checked one cycle after a write because the configuration words are registered. Each tick depends only on registered counter state, so the bench's reference model predicts every tick for the current cycle and advances at each clock, applying a write only at the edge that captures it. The model is compared at every falling edge. Period checks count rising edges between consecutive ticks, and they begin only after one tick has passed, so every counter has reloaded with the current settings. The mid-count write case is measured from the tick before the write, so the old reload value still governs that interval.

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int NCH       = 5,
  parameter int PS_W      = 8,
  parameter int SEL_W     = 4,
  parameter int MAX_SHIFT = 7,
  parameter int GRP0      = 2,
  parameter int DW        = 32,
  parameter logic [15:0] CFG0_RST = 16'h0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [NCH-1:0] tick
);
  localparam int C0_W = 2 * PS_W;
  localparam int C1_W = NCH * SEL_W;
  localparam int DC_W = MAX_SHIFT;

  logic [C0_W-1:0] cfg0;
  logic [C1_W-1:0] cfg1;
  logic [1:0]      pre_pulse;
  logic            unused_hi;

  assign unused_hi = ^wr_data[DW-1:C1_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0 <= C0_W'(CFG0_RST);
      cfg1 <= '0;
    end else if (wr_en) begin
      if (wr_sel) cfg1 <= wr_data[C1_W-1:0];
      else        cfg0 <= wr_data[C0_W-1:0];
    end
  end

  assign rd_data = rd_sel ? DW'(cfg1) : DW'(cfg0);

  for (genvar k = 0; k < 2; k++) begin : g_pre
    logic [PS_W-1:0] pcnt;
    assign pre_pulse[k] = (pcnt == '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pcnt <= '0;
      else if (pre_pulse[k]) pcnt <= cfg0[k*PS_W +: PS_W];
      else                   pcnt <= pcnt - 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int G = (c < GRP0) ? 0 : 1;
    logic [SEL_W-1:0] sel, shift;
    logic [DC_W:0]    span;
    logic [DC_W-1:0]  reload, dcnt;

    assign sel    = cfg1[c*SEL_W +: SEL_W];
    assign shift  = (sel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel;
    assign span   = (DC_W+1)'(1) << shift;
    assign reload = DC_W'(span - (DC_W+1)'(1));
    assign tick[c] = pre_pulse[G] & (dcnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            dcnt <= '0;
      else if (pre_pulse[G]) dcnt <= (dcnt == '0) ? reload : dcnt - 1'b1;
    end
  end
endmodule

// File: rtl/tick_divider_chk.sv
module tick_divider_chk #(
  parameter int NCH   = 5,
  parameter int PS_W  = 8,
  parameter int SEL_W = 4,
  parameter int GRP0  = 2,
  parameter int DW    = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  wr_sel,
  input logic [DW-1:0]         wr_data,
  input logic [NCH-1:0]        tick,
  input logic [2*PS_W-1:0]     cfg0,
  input logic [NCH*SEL_W-1:0]  cfg1,
  input logic [1:0]            pre_pulse
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DW-1:NCH*SEL_W];

  AST_CFG0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> cfg0 == $past(wr_data[2*PS_W-1:0])); // R2
  AST_CFG1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> cfg1 == $past(wr_data[NCH*SEL_W-1:0])); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg0) && $stable(cfg1)); // R2

  for (genvar k = 0; k < 2; k++) begin : g_pk
    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      pre_pulse[k] && (cfg0[k*PS_W +: PS_W] != '0) |=> !pre_pulse[k]); // R5
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ck
    localparam int G = (c < GRP0) ? 0 : 1;
    AST_TICK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] && (cfg0[G*PS_W +: PS_W] != '0) |=> !tick[c]); // R5
  end
endmodule

bind tick_divider tick_divider_chk #(
  .NCH(NCH), .PS_W(PS_W), .SEL_W(SEL_W), .GRP0(GRP0), .DW(DW)
) u_chk (.*);

// File: tb/test_tick_divider.sv
module test_tick_divider;
  localparam int NCH = 5;

  logic clk = 1'b0;
  logic rst_n, wr_en, wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic [NCH-1:0] tick;

  always #4 clk = ~clk;

  tick_divider i_tick_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick)
  );

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R5";
  int pc[2];
  int dc[NCH];
  int m_cfg0, m_cfg1;

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic int grp(int c);
    return (c < 2) ? 0 : 1;
  endfunction

  function automatic int shf(int c);
    int f = (m_cfg1 >> (4 * c)) & 15;
    return (f > 7) ? 7 : f;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      total++;
      bad++;
      $display("FAIL R5 watchdog expired act=%0d exp<=60000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin : model
    int et;
    if (!rst_n) begin
      pc = '{0, 0};
      for (int c = 0; c < NCH; c++) dc[c] = 0;
      m_cfg0 = 'h0101;
      m_cfg1 = 0;
    end else begin
      et = 0;
      for (int c = 0; c < NCH; c++)
        if (pc[grp(c)] == 0 && dc[c] == 0) et |= (1 << c);
      chk(cur_req, int'(tick), et, "tick");
      if (rd_sel) chk("R3", int'(rd_data), m_cfg1, "rd_data");
      else        chk("R2", int'(rd_data), m_cfg0, "rd_data");
      for (int c = 0; c < NCH; c++)
        if (pc[grp(c)] == 0) dc[c] = (dc[c] == 0) ? (1 << shf(c)) - 1 : dc[c] - 1;
      for (int k = 0; k < 2; k++)
        pc[k] = (pc[k] == 0) ? ((m_cfg0 >> (8 * k)) & 255) : pc[k] - 1;
      if (wr_en) begin
        if (wr_sel) m_cfg1 = int'(wr_data & 32'h000F_FFFF);
        else        m_cfg0 = int'(wr_data & 32'h0000_FFFF);
      end
    end
  end

  task automatic wr(logic sel, logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic measure(int ch, int exp, string req);
    int t0;
    do @(negedge clk); while (!tick[ch]);
    t0 = cyc;
    do @(negedge clk); while (!tick[ch]);
    chk(req, cyc - t0, exp, $sformatf("period ch%0d", ch));
  endtask

  initial begin
    int t1;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", int'(rd_data), 'h0101, "prescaler word in reset");
    rd_sel = 1'b1; #1;
    chk("R1", int'(rd_data), 0, "divider word in reset");
    rd_sel = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R7", int'(tick), 'h1f, "first cycle ticks");

    measure(0, 2, "R5");
    measure(2, 2, "R4");

    cur_req = "R4";
    wr(1'b0, 32'hFFFF_0203);
    wr(1'b1, 32'hFFF9_3021);
    @(posedge clk); #2 rd_sel = 1'b0;
    @(negedge clk) chk("R2", int'(rd_data), 'h0203, "prescaler readback");
    @(posedge clk); #2 rd_sel = 1'b1;
    @(negedge clk) chk("R3", int'(rd_data), 'h93021, "divider readback");
    @(posedge clk); #2 rd_sel = 1'b0;

    measure(0, 8, "R5");
    measure(1, 16, "R4");
    measure(2, 3, "R4");
    measure(3, 24, "R5");
    cur_req = "R6";
    measure(4, 384, "R6");
    wr(1'b1, 32'h000F_0000);
    measure(4, 384, "R6");

    cur_req = "R8";
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0000_00FF);
    measure(0, 256, "R8");
    t1 = cyc;
    repeat (20) @(negedge clk);
    wr(1'b0, 32'h0000_0001);
    do @(negedge clk); while (!tick[0]);
    chk("R8", cyc - t1, 256, "old prescaler count completes");
    measure(0, 2, "R8");
    wr(1'b1, 32'h0000_0003);
    measure(0, 16, "R8");

    cur_req = "R9";
    wr(1'b0, 32'h0);
    wr(1'b1, 32'h0);
    repeat (40) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9", int'(tick), 'h1f, "all ticks every cycle");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule